// File: doc/BRIEF.md
# Serial Word Transmit Buffer

This block sits between a host and a serial line driver. The host places up to eight data words into an internal buffer. While it loads, it holds the transmit enable low and pulses a load strobe once per word. When the host raises the enable, the block sends the buffered words in the order they were loaded. Each word goes out as a serial word of 25 or 32 bits, least significant bit first, so the 8-bit label leads. The block adds a fixed idle gap after every word.

The last bit of each serial word can carry a computed parity bit in place of a data bit. The parity is odd or even. Even parity is mainly useful for checking a receiver's parity logic.

A ready flag tells the host when the buffer has fully drained and can take a new block. A sticky overflow flag records any attempt to load a ninth word.

The block produces one symbol per bit time, timed by an internal clock-enable tick that divides the system clock. Each symbol is a data bit with a valid marker, or a null. Converting these symbols into line signalling is the job of a downstream stage.

Top module: `serial_tx_buffer`

## Requirements
- R1: After reset `tx_ready` is 1, `ovf` is 0 and `ser_valid` is 0. While `tx_ready` is 1 no bit is sent.
- R2: A load strobe accepted while the buffer is empty drives `tx_ready` to 0 on the next clock. `tx_ready` returns to 1 at the end of the last bit of the last buffered word.
- R3: A load strobe while `tx_en` is 1 is ignored: `tx_ready` stays 1, and no word is sent for it.
- R4: The buffer holds eight words and sends them first-in first-out. A strobe with the buffer full and `tx_en` at 0 is dropped and sets `ovf`, which stays 1 until reset.
- R5: `len32` = 1 sends 32-bit words (input bits 31..0). `len32` = 0 sends 25-bit words (input bits 24..0; bits 31..25 are unused).
- R6: Bits go out least significant first: input bit 0 (the first label bit) is the first symbol of a word.
- R7: Between consecutive words there are exactly 4 null bit times. This also holds when a new block is loaded and enabled within the gap that follows the previous block. A word never starts less than 4 bit times after the previous one.
- R8: With `par_en` = 1 the last bit of the word (position 31 or 24) is replaced by parity. With `par_even` = 0 the whole serial word holds an odd number of ones. With `par_even` = 1 it holds an even number of ones.
- R9: With `par_en` = 0 the last position carries input bit 31 or 24 unchanged.
- R10: `bit_tick` pulses for one clock every `CLK_PER_BIT` clocks. `ser_valid` and `ser_bit` change only on the clock edge at which `bit_tick` is 1.
- R11: While `tx_en` is 0 and no word is in progress, loaded words are held and nothing is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; empties the buffer and forces null output |
| ld_stb | input | 1 | One-clock load strobe for `ld_word` |
| ld_word | input | WORD_W | Word to buffer |
| tx_en | input | 1 | 1 = transmit buffered words; 0 = loading allowed |
| len32 | input | 1 | 1 = 32-bit serial word, 0 = 25-bit serial word |
| par_en | input | 1 | 1 = last bit of the word replaced by parity |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| bit_tick | output | 1 | One-clock pulse per bit time |
| ser_bit | output | 1 | Current serial bit (0 when null) |
| ser_valid | output | 1 | 1 = `ser_bit` is a data bit, 0 = null bit time |
| tx_ready | output | 1 | Buffer drained and ready for a new block |
| ovf | output | 1 | Sticky: a load was dropped because the buffer was full |

## Verification
The bench reloads and re-enables the block within the 4-bit gap that follows a drained block. A gap counter that restarted on enable, or was skipped when the buffer was empty, would show up there as a gap of other than 4 null bits. The bench also loads nine words. A design that overwrote the oldest entry, or wrapped its fill count, would send the wrong sequence or fail to raise `ovf`.

Parity is checked in both word lengths and both polarities, and with parity disabled using word values whose top bit makes each case visible. A parity computed over the wrong span, or placed at bit 31 in short-word mode, shows up as a mismatching symbol. A strobe given while enabled and idle must leave `tx_ready` high and produce no output. A design that accepted it would drop `tx_ready` and send an unexpected word.

// File: rtl/txb_pkg.sv
package txb_pkg;
    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_GAP   = 2'd2
    } ser_state_e;
endpackage

// File: rtl/txb_tick.sv
module txb_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == TW'(DIV - 1));
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/txb_fifo.sv
module txb_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_stb,
    input  logic          tx_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    input  logic          last_done,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          ready,
    output logic          ovf
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     rdy;
        logic                     ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     wr_try, wr_ok;

    always_comb begin
        st_d   = st_q;
        wr_try = ld_stb && !tx_en;
        wr_ok  = wr_try && (st_q.cnt != CW'(DEPTH));
        if (wr_try && !wr_ok) st_d.ovf = 1'b1;
        if (wr_ok) begin
            st_d.mem[st_q.wp] = wr_data;
            st_d.wp  = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.rdy = 1'b0;
        end else if (pop && st_q.cnt != '0) begin
            st_d.rp  = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (last_done && st_q.cnt == '0 && !wr_ok) st_d.rdy = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rdy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign ready = st_q.rdy;
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/txb_shift.sv
module txb_shift
    import txb_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SW  = 25,
    parameter int GAP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tx_en,
    input  logic          empty,
    input  logic [DW-1:0] head,
    input  logic          len32,
    input  logic          par_en,
    input  logic          par_even,
    output logic          pop,
    output logic          last_done,
    output logic          ser_bit,
    output logic          ser_valid
);
    localparam int BW = $clog2(DW);
    localparam int GW = $clog2(GAP) + 1;

    typedef struct packed {
        ser_state_e    st;
        logic [DW-1:0] sh;
        logic [BW-1:0] bcnt;
        logic [BW-1:0] lenm1;
        logic [GW-1:0] gcnt;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      start;

    function automatic logic [DW-1:0] frame(input logic [DW-1:0] w,
                                            input logic lng, input logic pe,
                                            input logic ev);
        logic [DW-1:0] f;
        logic          par;
        f   = '0;
        par = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (lng || i < SW) f[i] = w[i];
            if ((lng && i < DW - 1) || (!lng && i < SW - 1)) par = par ^ w[i];
        end
        if (pe) begin
            if (lng) f[DW-1] = ev ? par : ~par;
            else     f[SW-1] = ev ? par : ~par;
        end
        return f;
    endfunction

    always_comb begin
        st_d      = st_q;
        pop       = 1'b0;
        last_done = 1'b0;
        start     = tx_en && !empty;
        if (tick) begin
            unique case (st_q.st)
                SER_SHIFT: begin
                    st_d.sh = st_q.sh >> 1;
                    if (st_q.bcnt == st_q.lenm1) begin
                        last_done = 1'b1;
                        st_d.st   = SER_GAP;
                        st_d.gcnt = '0;
                    end else begin
                        st_d.bcnt = st_q.bcnt + 1'b1;
                    end
                end
                SER_GAP: begin
                    if (st_q.gcnt == GW'(GAP - 1)) begin
                        st_d.st = SER_IDLE;
                    end else begin
                        st_d.gcnt = st_q.gcnt + 1'b1;
                    end
                end
                default: ;
            endcase
            if (start && (st_q.st == SER_IDLE ||
                          (st_q.st == SER_GAP && st_q.gcnt == GW'(GAP - 1)))) begin
                pop        = 1'b1;
                st_d.st    = SER_SHIFT;
                st_d.sh    = frame(head, len32, par_en, par_even);
                st_d.bcnt  = '0;
                st_d.lenm1 = len32 ? BW'(DW - 1) : BW'(SW - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= SER_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_valid = (st_q.st == SER_SHIFT);
    assign ser_bit   = (st_q.st == SER_SHIFT) && st_q.sh[0];
endmodule

// File: rtl/serial_tx_buffer.sv
module serial_tx_buffer #(
    parameter int WORD_W      = 32,
    parameter int SHORT_W     = 25,
    parameter int DEPTH       = 8,
    parameter int GAP_BITS    = 4,
    parameter int CLK_PER_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              tx_en,
    input  logic              len32,
    input  logic              par_en,
    input  logic              par_even,
    output logic              bit_tick,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              tx_ready,
    output logic              ovf
);
    logic [WORD_W-1:0] head;
    logic              empty, pop, last_done;

    txb_tick #(.DIV(CLK_PER_BIT)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick)
    );

    txb_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_stb    (ld_stb),
        .tx_en     (tx_en),
        .wr_data   (ld_word),
        .pop       (pop),
        .last_done (last_done),
        .head      (head),
        .empty     (empty),
        .ready     (tx_ready),
        .ovf       (ovf)
    );

    txb_shift #(.DW(WORD_W), .SW(SHORT_W), .GAP(GAP_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .tx_en     (tx_en),
        .empty     (empty),
        .head      (head),
        .len32     (len32),
        .par_en    (par_en),
        .par_even  (par_even),
        .pop       (pop),
        .last_done (last_done),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid)
    );
endmodule

// File: rtl/txb_chk.sv
module txb_chk (
    input logic clk,
    input logic rst_n,
    input logic ld_stb,
    input logic tx_en,
    input logic bit_tick,
    input logic ser_bit,
    input logic ser_valid,
    input logic tx_ready,
    input logic ovf
);
    assert_null_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !ser_valid);

    assert_ready_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && !tx_en && tx_ready) |=> !tx_ready);

    assert_load_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && tx_en && tx_ready) |=> tx_ready);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(ld_stb && !tx_en));

    assert_tick_paced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> ($stable(ser_valid) && $stable(ser_bit)));
endmodule

bind serial_tx_buffer txb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_stb    (ld_stb),
    .tx_en     (tx_en),
    .bit_tick  (bit_tick),
    .ser_bit   (ser_bit),
    .ser_valid (ser_valid),
    .tx_ready  (tx_ready),
    .ovf       (ovf)
);

// File: tb/sim_serial_tx_buffer.sv
module sim_serial_tx_buffer;
    localparam int DIV = 4;
    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_stb = 1'b0;
    logic [31:0] ld_word = '0;
    logic        tx_en = 1'b0;
    logic        len32 = 1'b1;
    logic        par_en = 1'b1;
    logic        par_even = 1'b0;
    logic        bit_tick, ser_bit, ser_valid, tx_ready, ovf;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic  b;
        bit    first;
        bit    last;
        bit    exact;
        int    idx;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    serial_tx_buffer #(.CLK_PER_BIT(DIV), .GAP_BITS(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_word(ld_word),
        .tx_en(tx_en), .len32(len32), .par_en(par_en), .par_even(par_even),
        .bit_tick(bit_tick), .ser_bit(ser_bit), .ser_valid(ser_valid),
        .tx_ready(tx_ready), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    // driver: pulses the strobe and pushes the expected symbols when accepted
    task automatic load(input logic [31:0] w, input bit expect_sent, input bit exact,
                        input string tag);
        int   n;
        int   ones;
        logic p;
        @(negedge clk);
        ld_stb  = 1'b1;
        ld_word = w;
        @(negedge clk);
        ld_stb  = 1'b0;
        if (expect_sent) begin
            n    = len32 ? 32 : 25;
            ones = 0;
            for (int i = 0; i < n - 1; i++) ones += int'(w[i]);
            p = par_even ? ones[0] : ~ones[0];
            for (int i = 0; i < n; i++) begin
                exp_t e;
                e.b     = (i == n - 1 && par_en) ? p : w[i];
                e.first = (i == 0);
                e.last  = (i == n - 1);
                e.exact = exact;
                e.idx   = i;
                e.tag   = tag;
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!tx_ready);
    endtask

    task automatic idle_bits(input int nb);
        repeat (nb * DIV) @(negedge clk);
    endtask

    // monitor: one symbol per bit time, sampled in the last clock of the period
    int          gap = 1000;
    int          werr = 0;
    logic [31:0] act_w = '0;
    logic [31:0] exp_w = '0;

    always @(negedge clk) begin
        if (rst_n && bit_tick) begin
            if (ser_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 R3 unexpected bit sent", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.first) begin
                        if (e.exact) chk(gap == GAP, "R7 gap between words", gap, GAP);
                        else         chk(gap >= GAP, "R7 minimum gap before word", gap, GAP);
                        werr  = 0;
                        act_w = '0;
                        exp_w = '0;
                    end
                    act_w[e.idx] = ser_bit;
                    exp_w[e.idx] = e.b;
                    if (ser_bit !== e.b) werr++;
                    if (e.last) begin
                        tests++;
                        if (werr != 0) begin
                            fails++;
                            $display("FAIL %s word bits: actual %h expected %h",
                                     e.tag, act_w, exp_w);
                        end
                    end
                end
                gap = 0;
            end else if (gap < 1000) begin
                gap++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R2 watchdog: actual hung expected drained");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int per;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tx_ready == 1'b1, "R1 ready after reset", int'(tx_ready), 1);
        chk(ovf == 1'b0, "R1 ovf after reset", int'(ovf), 0);
        chk(ser_valid == 1'b0, "R1 null after reset", int'(ser_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 tick period
        do @(negedge clk); while (!bit_tick);
        per = 0;
        do begin @(negedge clk); per++; end while (!bit_tick);
        chk(per == DIV, "R10 tick period", per, DIV);

        // 32-bit, odd parity, block of three
        len32 = 1'b1; par_en = 1'b1; par_even = 1'b0;
        load(32'hA5C3_0F81, 1'b1, 1'b0, "R5 R6 R8 odd32");
        chk(tx_ready == 1'b0, "R2 ready clears on load", int'(tx_ready), 0);
        load(32'h0000_0001, 1'b1, 1'b1, "R6 R8 odd32 lsb");
        load(32'hFFFF_FFFF, 1'b1, 1'b1, "R8 odd32 ones");
        idle_bits(20);
        chk(ser_valid == 1'b0, "R11 held while disabled", int'(ser_valid), 0);
        tx_en = 1'b1;
        wait_ready();
        chk(exp_q.size() == 0, "R2 ready only after last word", exp_q.size(), 0);

        // strobe while enabled is ignored
        load(32'h1234_5678, 1'b0, 1'b0, "R3");
        idle_bits(2);
        chk(tx_ready == 1'b1, "R3 ready kept on ignored load", int'(tx_ready), 1);
        idle_bits(45);
        chk(ser_valid == 1'b0, "R3 nothing sent for ignored load", int'(ser_valid), 0);

        // 25-bit, even parity
        tx_en = 1'b0; len32 = 1'b0; par_even = 1'b1;
        load(32'hFE12_3457, 1'b1, 1'b0, "R5 R8 even25");
        load(32'h0080_00FF, 1'b1, 1'b1, "R5 R8 even25 b");
        tx_en = 1'b1;
        wait_ready();

        // parity disabled, both lengths
        tx_en = 1'b0; par_en = 1'b0; par_even = 1'b0;
        load(32'h0100_0003, 1'b1, 1'b0, "R9 data25 top1");
        load(32'hFEFF_FFFF, 1'b1, 1'b1, "R9 data25 top0");
        tx_en = 1'b1;
        wait_ready();
        tx_en = 1'b0; len32 = 1'b1;
        load(32'h8000_0000, 1'b1, 1'b0, "R9 data32 top1");
        load(32'h7FFF_0000, 1'b1, 1'b1, "R9 data32 top0");
        tx_en = 1'b1;
        wait_ready();

        // fill plus one
        tx_en = 1'b0; par_en = 1'b1;
        for (int k = 0; k < 9; k++)
            load(32'h1111_0000 * (k + 1) + 32'(k), k < 8, k != 0, "R4 fifo order");
        chk(ovf == 1'b1, "R4 overflow flag", int'(ovf), 1);
        tx_en = 1'b1;
        wait_ready();
        chk(ovf == 1'b1, "R4 overflow sticky", int'(ovf), 1);

        // reload inside the gap after drain
        tx_en = 1'b0;
        load(32'h5A5A_A5A5, 1'b1, 1'b1, "R7 quick reload");
        tx_en = 1'b1;
        wait_ready();
        idle_bits(8);
        chk(exp_q.size() == 0, "R2 all words sent", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule